// File: doc/BRIEF.md
# Processor Bus Strobe Decoder and Address Latch

This block sits between a processor with a multiplexed 16-bit address/data bus and the system buses. It turns the processor's three bus-control lines (direction, control 2, control 1) into eight separate active-low bus-state strobes. Decoding is gated by a four-phase clock, so a strobe can be active only in phases 2, 3 and 4. The strobes are active-low so that, on the board, several drivers can share each line as wired-OR.

During phase 4 of an address-carrying bus state, the block captures the address from the processor data lines into a holding register. It drives that register onto the address bus through an output enable. A DMA master can take the address bus: while the processor grants the bus (request and acknowledge both low), a low disable request releases the address output enable. A separate force input makes the address bus show all ones, so a trap can store the program counter at the top location. The block also keeps the direction control for the data bus buffer. This control is parked in the bus-to-processor direction during phase 1. When phase 1 ends, it takes the direction line.

Top module: `cpu_bus_ctl`

## Requirements
- R1: The state code is {bdir, bc2, bc1}. Code value k selects strobe_n[k]: 0 idle, 1 address-to-register, 2 interrupt address, 3 data-to-bus, 4 bus-address-register, 5 data-write, 6 data-write-strobe, 7 interrupt-acknowledge. In phases 2 to 4 exactly that strobe is low and all others are high.
- R2: While phase 1 is active (phase[0] high), or no phase bit is set, all strobe_n bits are high.
- R3: At a clock edge with phase[3] high and state code 1, 4 or 7, the address register takes cpu_data. The new value appears on addr_out after that edge.
- R4: In every other state code, and in phases other than 4, the address register keeps its value.
- R5: When dis_addr_n, busrq_n and busak_n are all low, addr_oe is low. Otherwise addr_oe is high, including in the same cycle that any one of them rises.
- R6: While force_max_n is low, addr_out is all ones. Releasing it shows the stored address again, unchanged.
- R7: A clock edge with phase[0] high sets data_to_bus to 0 (bus toward the processor).
- R8: At the first clock edge after phase[0] falls, data_to_bus takes the value of bdir, and it then holds until the next phase 1.
- R9: After reset, addr_out is zero and data_to_bus is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bdir | input | 1 | Processor bus direction line |
| bc2 | input | 1 | Processor bus control 2 |
| bc1 | input | 1 | Processor bus control 1 |
| phase | input | 4 | One-hot phase strobes, bit 0 = phase 1 |
| cpu_data | input | 16 | Processor multiplexed data lines |
| busrq_n | input | 1 | Bus request, active low |
| busak_n | input | 1 | Bus acknowledge, active low |
| dis_addr_n | input | 1 | Address bus release request, active low |
| force_max_n | input | 1 | Force all-ones address, active low |
| strobe_n | output | 8 | Decoded bus-state strobes, active low |
| addr_out | output | 16 | Address bus value |
| addr_oe | output | 1 | Address bus drive enable (low = floated) |
| data_to_bus | output | 1 | Data buffer direction, 1 = processor to bus |

## Verification
The bench builds the block with its default parameters: a 16-bit address and data path, a three-bit state code giving eight strobes, and four phases. With these values every state code can be stepped through in each phase. The load gate can be tried against all eight codes. Distinct 16-bit patterns, including zero and patterns near all ones, show the force path apart from a genuinely stored maximum address.

// File: rtl/cpu_bus_pkg.sv
package cpu_bus_pkg;
   localparam int unsigned CODE_W = 3;
   localparam int unsigned N_STATES = 1 << CODE_W;

   typedef enum logic [CODE_W-1:0] {
      ST_IDLE  = 3'd0,
      ST_ADDR  = 3'd1,
      ST_IADR  = 3'd2,
      ST_RDBUS = 3'd3,
      ST_BADR  = 3'd4,
      ST_WR    = 3'd5,
      ST_WRS   = 3'd6,
      ST_IACK  = 3'd7
   } bus_state_e;

   function automatic logic is_addr_load(input bus_state_e s);
      return (s == ST_ADDR) || (s == ST_BADR) || (s == ST_IACK);
   endfunction
endpackage

// File: rtl/bus_state_decoder.sv
module bus_state_decoder
   import cpu_bus_pkg::*;
#(
   parameter int unsigned NPH = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  bus_state_e          state,
   input  logic [NPH-1:0]      phase,
   output logic [N_STATES-1:0] strobe_n
);
   logic enable;

   assign enable = !phase[0] && (|phase[NPH-1:1]);

   for (genvar i = 0; i < N_STATES; i++) begin : g_strobe
      assign strobe_n[i] = !(enable && (state == bus_state_e'(i)));
   end

   AST_IDLE_PH1: assert property (@(posedge clk) disable iff (!rst_n)
      phase[0] |-> (&strobe_n)); // R2
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!phase[0] && (|phase[NPH-1:1])) |-> ($countones(~strobe_n) == 1)); // R1
endmodule

// File: rtl/addr_latch.sv
module addr_latch
   import cpu_bus_pkg::*;
#(
   parameter int unsigned AW = 16,
   parameter int unsigned NPH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  bus_state_e     state,
   input  logic [NPH-1:0] phase,
   input  logic [AW-1:0]  din,
   input  logic           force_max_n,
   output logic [AW-1:0]  addr
);
   localparam int unsigned LOAD_PH = NPH - 1;
   localparam logic [AW-1:0] ADDR_TOP = {AW{1'b1}};

   logic [AW-1:0] addr_q;
   logic          load;

   assign load = phase[LOAD_PH] && is_addr_load(state);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q <= '0;
      else if (load) addr_q <= din;
   end

   assign addr = force_max_n ? addr_q : ADDR_TOP;

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (addr_q == $past(din))); // R3
   AST_HOLD_ELSE: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(addr_q)); // R4
   AST_FORCE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      !force_max_n |-> (&addr)); // R6
endmodule

// File: rtl/data_dir_ctl.sv
module data_dir_ctl #(
   parameter int unsigned NPH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NPH-1:0] phase,
   input  logic           bdir,
   output logic           to_bus
);
   logic ph1_q;
   logic dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph1_q <= 1'b0;
         dir_q <= 1'b0;
      end else begin
         ph1_q <= phase[0];
         if (phase[0])   dir_q <= 1'b0;
         else if (ph1_q) dir_q <= bdir;
      end
   end

   assign to_bus = dir_q;

   AST_DIR_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      phase[0] |=> !to_bus); // R7
   AST_DIR_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (ph1_q && !phase[0]) |=> (to_bus == $past(bdir))); // R8
endmodule

// File: rtl/cpu_bus_ctl.sv
module cpu_bus_ctl
   import cpu_bus_pkg::*;
#(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 16,
   parameter int unsigned NPH = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bdir,
   input  logic                bc2,
   input  logic                bc1,
   input  logic [NPH-1:0]      phase,
   input  logic [DW-1:0]       cpu_data,
   input  logic                busrq_n,
   input  logic                busak_n,
   input  logic                dis_addr_n,
   input  logic                force_max_n,
   output logic [N_STATES-1:0] strobe_n,
   output logic [AW-1:0]       addr_out,
   output logic                addr_oe,
   output logic                data_to_bus
);
   if (AW != DW) begin : g_bad_width
      $error("cpu_bus_ctl: address width must equal data width");
   end
   if (NPH < 2) begin : g_bad_phase
      $error("cpu_bus_ctl: at least two phases are required");
   end

   bus_state_e state;
   logic       dma_owns;

   assign state = bus_state_e'({bdir, bc2, bc1});

   bus_state_decoder #(.NPH(NPH)) u_dec (
      .clk(clk), .rst_n(rst_n), .state(state), .phase(phase), .strobe_n(strobe_n)
   );

   addr_latch #(.AW(AW), .NPH(NPH)) u_adr (
      .clk(clk), .rst_n(rst_n), .state(state), .phase(phase),
      .din(cpu_data), .force_max_n(force_max_n), .addr(addr_out)
   );

   data_dir_ctl #(.NPH(NPH)) u_dir (
      .clk(clk), .rst_n(rst_n), .phase(phase), .bdir(bdir), .to_bus(data_to_bus)
   );

   assign dma_owns = !dis_addr_n && !busrq_n && !busak_n;
   assign addr_oe  = !dma_owns;

   AST_OE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      (!dis_addr_n && !busrq_n && !busak_n) |-> !addr_oe); // R5
   AST_OE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_addr_n || busak_n) |-> addr_oe); // R5
endmodule

// File: tb/cpu_bus_ctl_tb.sv
module cpu_bus_ctl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bdir = 1'b0, bc2 = 1'b0, bc1 = 1'b0;
   logic [3:0]  phase = 4'b0001;
   logic [15:0] cpu_data = '0;
   logic        busrq_n = 1'b1, busak_n = 1'b1, dis_addr_n = 1'b1, force_max_n = 1'b1;
   logic [7:0]  strobe_n;
   logic [15:0] addr_out;
   logic        addr_oe;
   logic        data_to_bus;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cpu_bus_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .bdir(bdir), .bc2(bc2), .bc1(bc1), .phase(phase),
      .cpu_data(cpu_data), .busrq_n(busrq_n), .busak_n(busak_n),
      .dis_addr_n(dis_addr_n), .force_max_n(force_max_n), .strobe_n(strobe_n),
      .addr_out(addr_out), .addr_oe(addr_oe), .data_to_bus(data_to_bus)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_code(input logic [2:0] c);
      {bdir, bc2, bc1} = c;
   endtask

   // drive at falling edge, let one rising edge pass, sample at next falling edge
   task automatic step;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      check(addr_out == 16'h0, "R9 addr after reset", addr_out, 0);
      check(data_to_bus == 1'b0, "R9 dir after reset", data_to_bus, 0);
   endtask

   task automatic t_decode;
      for (int p = 1; p < 4; p++) begin
         for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            phase = 4'b0001 << p;
            set_code(3'(c));
            #1;
            check(strobe_n == ~(8'b1 << c), "R1 decode", strobe_n, ~(8'b1 << c));
         end
      end
   endtask

   task automatic t_idle;
      for (int c = 0; c < 8; c++) begin
         @(negedge clk);
         phase = 4'b0001;
         set_code(3'(c));
         #1;
         check(strobe_n == 8'hFF, "R2 phase1 idle", strobe_n, 8'hFF);
      end
      @(negedge clk);
      phase = 4'b0000;
      set_code(3'd5);
      #1;
      check(strobe_n == 8'hFF, "R2 no phase", strobe_n, 8'hFF);
   endtask

   task automatic load(input logic [2:0] c, input logic [3:0] ph, input logic [15:0] d);
      @(negedge clk);
      set_code(c);
      phase = ph;
      cpu_data = d;
      step();
   endtask

   task automatic t_load;
      load(3'd1, 4'b1000, 16'h1234);
      check(addr_out == 16'h1234, "R3 load code1", addr_out, 16'h1234);
      load(3'd4, 4'b1000, 16'hA5C3);
      check(addr_out == 16'hA5C3, "R3 load code4", addr_out, 16'hA5C3);
      load(3'd7, 4'b1000, 16'h0F0F);
      check(addr_out == 16'h0F0F, "R3 load code7", addr_out, 16'h0F0F);
   endtask

   task automatic t_hold;
      for (int c = 0; c < 8; c++) begin
         if (c == 1 || c == 4 || c == 7) continue;
         load(3'(c), 4'b1000, 16'hDEAD);
         check(addr_out == 16'h0F0F, "R4 hold other code", addr_out, 16'h0F0F);
      end
      load(3'd1, 4'b0010, 16'hBEEF);
      check(addr_out == 16'h0F0F, "R4 hold phase2", addr_out, 16'h0F0F);
      load(3'd7, 4'b0100, 16'hBEEF);
      check(addr_out == 16'h0F0F, "R4 hold phase3", addr_out, 16'h0F0F);
      load(3'd4, 4'b0001, 16'hBEEF);
      check(addr_out == 16'h0F0F, "R4 hold phase1", addr_out, 16'h0F0F);
   endtask

   task automatic t_oe;
      @(negedge clk);
      busrq_n = 1'b0; busak_n = 1'b0; dis_addr_n = 1'b0;
      #1 check(addr_oe == 1'b0, "R5 float", addr_oe, 0);
      @(negedge clk);
      busak_n = 1'b1;
      #1 check(addr_oe == 1'b1, "R5 ack removed", addr_oe, 1);
      @(negedge clk);
      busak_n = 1'b0; dis_addr_n = 1'b1;
      #1 check(addr_oe == 1'b1, "R5 disable removed", addr_oe, 1);
      @(negedge clk);
      dis_addr_n = 1'b0; busrq_n = 1'b1;
      #1 check(addr_oe == 1'b1, "R5 no request", addr_oe, 1);
      @(negedge clk);
      busrq_n = 1'b1; busak_n = 1'b1; dis_addr_n = 1'b1;
   endtask

   task automatic t_force;
      @(negedge clk);
      force_max_n = 1'b0;
      #1 check(addr_out == 16'hFFFF, "R6 forced", addr_out, 16'hFFFF);
      load(3'd0, 4'b0010, 16'h0000);
      check(addr_out == 16'hFFFF, "R6 forced held", addr_out, 16'hFFFF);
      @(negedge clk);
      force_max_n = 1'b1;
      #1 check(addr_out == 16'h0F0F, "R6 released", addr_out, 16'h0F0F);
      load(3'd4, 4'b1000, 16'hFFFE);
      check(addr_out == 16'hFFFE, "R6 near top stored", addr_out, 16'hFFFE);
   endtask

   task automatic t_dir;
      // bdir high at end of phase 1
      @(negedge clk); phase = 4'b0001; set_code(3'd5);
      step();
      check(data_to_bus == 1'b0, "R7 parked in phase1", data_to_bus, 0);
      @(negedge clk); phase = 4'b0010;
      step();
      check(data_to_bus == 1'b1, "R8 take bdir high", data_to_bus, 1);
      @(negedge clk); phase = 4'b0100; set_code(3'd3);
      step();
      check(data_to_bus == 1'b1, "R8 holds after capture", data_to_bus, 1);
      @(negedge clk); phase = 4'b0001; set_code(3'd6);
      step();
      check(data_to_bus == 1'b0, "R7 parked again", data_to_bus, 0);
      @(negedge clk); phase = 4'b0010; set_code(3'd3);
      step();
      check(data_to_bus == 1'b0, "R8 take bdir low", data_to_bus, 0);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_decode();
      t_idle();
      t_load();
      t_hold();
      t_oe();
      t_force();
      t_dir();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule